// File: doc/BRIEF.md
# Single-Wire Bus Power and Loopback Controller

This block sits between the digital transmit/receive core of a single-wire serial network controller and the transceiver pins. It owns three concerns that lie outside message framing. The first is a low-power stop state, which is left when the bus becomes active. The second is a digital loopback that returns the core's transmit stream to its receive input without touching the pins. The third is an analog-loopback flag that holds off transmission until the bus has been seen idle.

Stop is entered only when the wake-control bit is already in force and a stop request then arrives while the core is not sending. In stop, the clock enable for the surrounding core is dropped, and the raw receive pin is watched by an edge latch that needs no clock. A rising edge on that pin raises a wake interrupt and restores the clock enable. The frame that caused the wake is blanked from the core until the line has been passive for a full idle period. The active mode bits are loaded from the configuration inputs only while the block reports not-busy. A change made while busy therefore takes effect at the next idle detection.

Top module: `sbus_mode_ctl`

## Requirements
- R1: While reset is held, the outputs are: clk_en=1, wake_irq=0, stop_err=0, core_rx=0, bus_tx_pin=0 (with core_tx=0) and busy=1.
- R2: On the clock after stop_req is sampled high, clk_en goes to 0, provided the active wake-control bit is set and tx_busy is low. stop_req with the bit clear, or the bit set with no stop_req, leaves clk_en at 1.
- R3: stop_req sampled while tx_busy=1 does not enter stop and sets stop_err. stop_err stays 1 until err_clr is pulsed.
- R4: While stopped (clk_en=0), tx_en=0, core_rx=0 and bus_tx_pin=0, and the block stays stopped while bus_rx_pin remains passive (0).
- R5: A 0-to-1 edge on bus_rx_pin during stop raises wake_irq and restores clk_en within 4 clocks. wake_irq then stays 1 until wake_ack is pulsed.
- R6: After a wake, core_rx is held at 0 and tx_en at 0 until bus_rx_pin has been passive for IDLE_CYC clocks. Normal operation then resumes.
- R7: With digital loopback active, bus_tx_pin is 0, core_rx equals core_tx, and bus_rx_pin has no effect on core_rx.
- R8: In normal operation, bus_tx_pin equals core_tx and core_rx follows bus_rx_pin two clocks later.
- R9: busy is 1 while tx_busy is 1, or until the receive line has been passive (0) for IDLE_CYC consecutive clocks. An active (1) level restarts that count.
- R10: When analog loopback is cleared, tx_en drops to 0 and returns to 1 only after a fresh idle period of IDLE_CYC clocks. Setting analog loopback alone leaves tx_en and the data paths unchanged.
- R11: The configuration bits are loaded into the active mode only while busy=0. A change made while busy takes effect after the next idle detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wake_en | input | 1 | Wake-control bit; enables stop entry |
| cfg_dig_lb | input | 1 | Digital loopback request |
| cfg_ana_lb | input | 1 | Analog loopback flag |
| stop_req | input | 1 | Request to enter stop (single-cycle pulse) |
| tx_busy | input | 1 | Core is transmitting |
| wake_ack | input | 1 | Write-one-to-clear for wake_irq |
| err_clr | input | 1 | Write-one-to-clear for stop_err |
| bus_rx_pin | input | 1 | Receive line from transceiver (1 = active) |
| core_tx | input | 1 | Transmit data from the core |
| bus_tx_pin | output | 1 | Transmit line to transceiver |
| core_rx | output | 1 | Receive data to the core |
| wake_irq | output | 1 | Non-maskable wake interrupt request |
| tx_en | output | 1 | Core may transmit |
| clk_en | output | 1 | Clock enable for the controller core |
| stop_err | output | 1 | Sticky: stop requested during a transmission |
| busy | output | 1 | Transmission in progress or bus not idle |

## Verification
The assertions assume the following about the inputs: stop_req is a single-cycle pulse, wake_ack and err_clr are single-cycle pulses, and configuration bits are changed between clocks rather than at an edge. The stimulus drives every input at the falling clock edge. It raises bus_rx_pin during stop only after clk_en has been seen low. It changes the mode bits either while the bus is idle or deliberately while the bus is held active, in order to exercise the deferred load. Wake frames are held for many clocks, so the two-stage synchronizer always sees them.

// File: rtl/sbus_pkg.sv
// Shared types for the single-wire bus mode controller.
package sbus_pkg;
    // Power state of the link: running, clock-stopped, or post-wake blanking.
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_STOP  = 2'd1,
        ST_BLANK = 2'd2
    } sbus_st_e;
endpackage

// File: rtl/sbus_sync.sv
// Multi-stage synchronizer for a single asynchronous bit.
// Assumes the input is held for longer than a clock period.
module sbus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the sampled bit through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sbus_edge_latch.sv
// Clockless capture of a rising edge on the bus pin, used while the clock
// enable is off. Held clear whenever arm is low. Assumes arm comes from a flop.
module sbus_edge_latch (
    input  logic pin,
    input  logic arm,
    output logic seen
);
    // Set on a pin rising edge while armed; cleared asynchronously when disarmed.
    always_ff @(posedge pin or negedge arm) begin
        if (!arm) seen <= 1'b0;
        else      seen <= 1'b1;
    end
endmodule

// File: rtl/sbus_idle_det.sv
// Declares the bus idle after IDLE_CYC consecutive passive (0) samples.
// An active sample or a restart pulse clears the count.
module sbus_idle_det #(
    parameter int IDLE_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic restart,
    output logic idle
);
    localparam int CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYC);

    logic [CW-1:0] cnt;

    // Count passive cycles and saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (restart || line)  cnt <= '0;
        else if (cnt != LIMIT)     cnt <= cnt + 1'b1;
    end

    assign idle = (cnt == LIMIT);
endmodule

// File: rtl/sbus_mode_regs.sv
// Active mode bits, loaded from configuration only while not busy, plus the
// hold that keeps transmission off after analog loopback is left.
module sbus_mode_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic idle,
    input  logic cfg_wake_en,
    input  logic cfg_dig_lb,
    input  logic cfg_ana_lb,
    output logic wake_act,
    output logic dig_act,
    output logic ana_act,
    output logic ana_hold,
    output logic ana_exit
);
    // Leaving analog loopback happens on the cycle the cleared bit is accepted.
    assign ana_exit = !busy && ana_act && !cfg_ana_lb;

    // Load the active mode from configuration while the block is not busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_act <= 1'b0;
            dig_act  <= 1'b0;
            ana_act  <= 1'b0;
        end else if (!busy) begin
            wake_act <= cfg_wake_en;
            dig_act  <= cfg_dig_lb;
            ana_act  <= cfg_ana_lb;
        end
    end

    // Hold transmission after analog loopback exit until a fresh idle period.
    always_ff @(posedge clk) begin
        if (!rst_n)        ana_hold <= 1'b0;
        else if (ana_exit) ana_hold <= 1'b1;
        else if (idle)     ana_hold <= 1'b0;
    end
endmodule

// File: rtl/sbus_pwr_fsm.sv
// Run / stop / blank sequencing, wake interrupt and stop-error flag.
// Assumes stop_req, wake_ack and err_clr are synchronous pulses.
module sbus_pwr_fsm
    import sbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic tx_busy,
    input  logic wake_act,
    input  logic wake_seen,
    input  logic idle,
    input  logic wake_ack,
    input  logic err_clr,
    output logic stopped,
    output logic running,
    output logic wake_irq,
    output logic stop_err,
    output logic wake_evt
);
    sbus_st_e st, st_nx;

    logic stop_ok, stop_bad;

    assign stop_ok  = (st == ST_RUN) && stop_req && wake_act && !tx_busy;
    assign stop_bad = (st == ST_RUN) && stop_req && tx_busy;
    assign wake_evt = (st == ST_STOP) && wake_seen;
    assign running  = (st == ST_RUN);

    // Next-state selection.
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_RUN:   if (stop_ok)  st_nx = ST_STOP;
            ST_STOP:  if (wake_seen) st_nx = ST_BLANK;
            ST_BLANK: if (idle)     st_nx = ST_RUN;
            default:                st_nx = ST_RUN;
        endcase
    end

    // State register and registered stop flag (glitch-free arm for the latch).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_RUN;
            stopped <= 1'b0;
        end else begin
            st      <= st_nx;
            stopped <= (st_nx == ST_STOP);
        end
    end

    // Wake interrupt: set on wake, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)        wake_irq <= 1'b0;
        else if (wake_evt) wake_irq <= 1'b1;
        else if (wake_ack) wake_irq <= 1'b0;
    end

    // Sticky error for a stop request during transmission.
    always_ff @(posedge clk) begin
        if (!rst_n)        stop_err <= 1'b0;
        else if (stop_bad) stop_err <= 1'b1;
        else if (err_clr)  stop_err <= 1'b0;
    end
endmodule

// File: rtl/sbus_mode_ctl.sv
// Top of the single-wire bus mode controller: routes data between pins and
// core according to the active mode, and handles stop, wake and idle gating.
// Assumes passive bus level 0, active level 1, and a free-running clk.
module sbus_mode_ctl #(
    parameter int IDLE_CYC    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wake_en,
    input  logic cfg_dig_lb,
    input  logic cfg_ana_lb,
    input  logic stop_req,
    input  logic tx_busy,
    input  logic wake_ack,
    input  logic err_clr,
    input  logic bus_rx_pin,
    input  logic core_tx,
    output logic bus_tx_pin,
    output logic core_rx,
    output logic wake_irq,
    output logic tx_en,
    output logic clk_en,
    output logic stop_err,
    output logic busy
);
    logic rx_s, line, idle, restart;
    logic wake_act, dig_act, ana_act, ana_hold, ana_exit;
    logic stopped, running, wake_evt;
    logic edge_seen, wake_seen;

    sbus_sync #(.STAGES(SYNC_STAGES)) u_rx_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_rx_pin), .q(rx_s)
    );

    sbus_edge_latch u_wake_latch (
        .pin(bus_rx_pin), .arm(stopped), .seen(edge_seen)
    );

    sbus_sync #(.STAGES(SYNC_STAGES)) u_wake_sync (
        .clk(clk), .rst_n(rst_n), .d(edge_seen), .q(wake_seen)
    );

    // The idle monitor watches the looped data in digital loopback.
    assign line    = dig_act ? core_tx : rx_s;
    assign restart = wake_evt | ana_exit;

    sbus_idle_det #(.IDLE_CYC(IDLE_CYC)) u_idle (
        .clk(clk), .rst_n(rst_n), .line(line), .restart(restart), .idle(idle)
    );

    assign busy = tx_busy | ~idle;

    sbus_mode_regs u_modes (
        .clk(clk), .rst_n(rst_n), .busy(busy), .idle(idle),
        .cfg_wake_en(cfg_wake_en), .cfg_dig_lb(cfg_dig_lb), .cfg_ana_lb(cfg_ana_lb),
        .wake_act(wake_act), .dig_act(dig_act), .ana_act(ana_act),
        .ana_hold(ana_hold), .ana_exit(ana_exit)
    );

    sbus_pwr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .tx_busy(tx_busy),
        .wake_act(wake_act), .wake_seen(wake_seen), .idle(idle),
        .wake_ack(wake_ack), .err_clr(err_clr), .stopped(stopped),
        .running(running), .wake_irq(wake_irq), .stop_err(stop_err),
        .wake_evt(wake_evt)
    );

    // Data routing: loopback, blanking and pin drive.
    always_comb begin
        bus_tx_pin = (running && !dig_act) ? core_tx : 1'b0;
        if (!running)     core_rx = 1'b0;
        else if (dig_act) core_rx = core_tx;
        else              core_rx = rx_s;
    end

    assign tx_en  = running && !ana_hold;
    assign clk_en = !stopped;
endmodule

// File: rtl/sbus_mode_ctl_chk.sv
// Property checker for sbus_mode_ctl, bound to every instance.
module sbus_mode_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic stop_req,
    input logic tx_busy,
    input logic wake_ack,
    input logic err_clr,
    input logic clk_en,
    input logic wake_irq,
    input logic stop_err,
    input logic tx_en,
    input logic core_rx,
    input logic bus_tx_pin,
    input logic wake_act,
    input logic dig_act,
    input logic ana_act
);
    // R2
    stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en) |-> ($past(stop_req) && $past(wake_act) && !$past(tx_busy)));

    // R3
    stop_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && tx_busy && clk_en) |=> stop_err);

    // R3
    stop_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_err && !err_clr) |=> stop_err);

    // R4
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> (!tx_en && !core_rx && !bus_tx_pin));

    // R5
    wake_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_irq) |-> !$past(clk_en));

    // R5
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_irq && !wake_ack) |=> wake_irq);

    // R7
    dig_lb_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dig_act |-> !bus_tx_pin);

    // R10
    ana_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ana_act) |-> !tx_en);
endmodule

bind sbus_mode_ctl sbus_mode_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .tx_busy(tx_busy),
    .wake_ack(wake_ack), .err_clr(err_clr), .clk_en(clk_en),
    .wake_irq(wake_irq), .stop_err(stop_err), .tx_en(tx_en),
    .core_rx(core_rx), .bus_tx_pin(bus_tx_pin), .wake_act(wake_act),
    .dig_act(dig_act), .ana_act(ana_act)
);

// File: tb/sim_sbus_mode_ctl.sv
module sim_sbus_mode_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wake_en = 0, cfg_dig_lb = 0, cfg_ana_lb = 0;
    logic stop_req = 0, tx_busy = 0, wake_ack = 0, err_clr = 0;
    logic bus_rx_pin = 0, core_tx = 0;
    logic bus_tx_pin, core_rx, wake_irq, tx_en, clk_en, stop_err, busy;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sbus_mode_ctl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wake_en(cfg_wake_en), .cfg_dig_lb(cfg_dig_lb),
        .cfg_ana_lb(cfg_ana_lb), .stop_req(stop_req), .tx_busy(tx_busy),
        .wake_ack(wake_ack), .err_clr(err_clr), .bus_rx_pin(bus_rx_pin),
        .core_tx(core_tx), .bus_tx_pin(bus_tx_pin), .core_rx(core_rx),
        .wake_irq(wake_irq), .tx_en(tx_en), .clk_en(clk_en),
        .stop_err(stop_err), .busy(busy)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        tick(3);
        chk("R1 clk_en", clk_en, 1'b1);
        chk("R1 wake_irq", wake_irq, 1'b0);
        chk("R1 stop_err", stop_err, 1'b0);
        chk("R1 core_rx", core_rx, 1'b0);
        chk("R1 bus_tx_pin", bus_tx_pin, 1'b0);
        chk("R1 busy", busy, 1'b1);
        rst_n = 1'b1;
        tick(80);
    endtask

    task automatic t_idle();
        chk("R9 idle after reset", busy, 1'b0);
        tx_busy = 1'b1; tick(1);
        chk("R9 tx_busy makes busy", busy, 1'b1);
        tx_busy = 1'b0; bus_rx_pin = 1'b1; tick(5);
        chk("R9 active line busy", busy, 1'b1);
        bus_rx_pin = 1'b0; tick(60);
        chk("R9 count not done", busy, 1'b1);
        tick(10);
        chk("R9 idle reached", busy, 1'b0);
    endtask

    task automatic t_normal();
        core_tx = 1'b1; tick(1);
        chk("R8 tx pass", bus_tx_pin, 1'b1);
        bus_rx_pin = 1'b1; tick(1);
        chk("R8 rx lag stage1", core_rx, 1'b0);
        tick(1);
        chk("R8 rx after two clocks", core_rx, 1'b1);
        bus_rx_pin = 1'b0; core_tx = 1'b0; tick(80);
    endtask

    task automatic t_defer_dig();
        bus_rx_pin = 1'b1; tick(5);
        cfg_dig_lb = 1'b1; tick(3); core_tx = 1'b1; tick(1);
        chk("R11 dig deferred while busy", bus_tx_pin, 1'b1);
        bus_rx_pin = 1'b0; tick(80);
        chk("R11 dig applied after idle", bus_tx_pin, 1'b0);
        chk("R7 loop rx=tx", core_rx, 1'b1);
        bus_rx_pin = 1'b1; core_tx = 1'b0; tick(3);
        chk("R7 pin ignored", core_rx, 1'b0);
        chk("R7 tx pin passive", bus_tx_pin, 1'b0);
        tick(80);
        cfg_dig_lb = 1'b0; bus_rx_pin = 1'b0; tick(80);
        core_tx = 1'b1; tick(1);
        chk("R7 loopback left", bus_tx_pin, 1'b1);
        core_tx = 1'b0; tick(1);
    endtask

    task automatic t_stop_gate();
        stop_req = 1'b1; tick(1); stop_req = 1'b0; tick(1);
        chk("R2 req without bit", clk_en, 1'b1);
        cfg_wake_en = 1'b1; tick(3);
        chk("R2 bit without req", clk_en, 1'b1);
        tx_busy = 1'b1; stop_req = 1'b1; tick(1);
        stop_req = 1'b0; tx_busy = 1'b0; tick(1);
        chk("R3 stop refused", clk_en, 1'b1);
        chk("R3 err set", stop_err, 1'b1);
        tick(5);
        chk("R3 err sticky", stop_err, 1'b1);
        err_clr = 1'b1; tick(1); err_clr = 1'b0;
        chk("R3 err cleared", stop_err, 1'b0);
        tick(80);
    endtask

    task automatic t_stop_wake();
        stop_req = 1'b1; tick(1); stop_req = 1'b0;
        chk("R2 stop entered", clk_en, 1'b0);
        core_tx = 1'b1; tick(1);
        chk("R4 tx pin quiet", bus_tx_pin, 1'b0);
        chk("R4 tx_en low", tx_en, 1'b0);
        core_tx = 1'b0; tick(20);
        chk("R4 stays stopped", clk_en, 1'b0);
        bus_rx_pin = 1'b1; tick(4);
        chk("R5 clk restored", clk_en, 1'b1);
        chk("R5 irq raised", wake_irq, 1'b1);
        chk("R6 frame blanked", core_rx, 1'b0);
        tick(20);
        chk("R6 still blanked", core_rx, 1'b0);
        chk("R5 irq held", wake_irq, 1'b1);
        wake_ack = 1'b1; tick(1); wake_ack = 1'b0;
        chk("R5 irq acked", wake_irq, 1'b0);
        bus_rx_pin = 1'b0; tick(40);
        chk("R6 tx_en held", tx_en, 1'b0);
        tick(40);
        chk("R6 tx_en resumed", tx_en, 1'b1);
        bus_rx_pin = 1'b1; tick(3);
        chk("R6 rx restored", core_rx, 1'b1);
        bus_rx_pin = 1'b0; tick(80);
    endtask

    task automatic t_analog();
        cfg_ana_lb = 1'b1; tick(3);
        chk("R10 set leaves tx_en", tx_en, 1'b1);
        cfg_ana_lb = 1'b0; tick(2);
        chk("R10 exit holds tx", tx_en, 1'b0);
        tick(30);
        chk("R10 still held", tx_en, 1'b0);
        tick(50);
        chk("R10 released after idle", tx_en, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all-reqs actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_idle();
        t_normal();
        t_defer_dig();
        t_stop_gate();
        t_stop_wake();
        t_analog();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule